// File: doc/BRIEF.md
# SDRAM Write and Mode-Register Sequencer

This block sits on the controller side of a two-bank, 16-bit SDRAM with 8-bit column addresses and drives the command pins, address bus and write data lines of that device. After reset it waits for a mode programming request, then issues a Mode Register Set. That command carries the burst length code, the addressing-mode bit and the CAS latency. Until this first programming step is done, no write is issued.

Once the mode is set, each host write request (bank, row, column) becomes an Activate, then a Write with Auto-Precharge after the row-to-column delay, then one data word per clock for the programmed burst length. The sequencer pulls data words from the host through a one-cycle take strobe. After the burst the bus stays on NOP for the write-recovery plus precharge interval, and the next request or mode update is only accepted after that. When full-page bursts are programmed, the write does not carry auto-precharge. In that case the sequencer closes the row itself with a Precharge command once write recovery has elapsed.

Top module: `sdram_wr_seq`

## Requirements
- R1: During and right after reset the bus carries NOP (chip select low, row strobe, column strobe and write enable high), DQ is not driven, wr_ready and mode_ack are low.
- R2: Before the first Mode Register Set, wr_ready stays low and no bus command is issued even when wr_valid is held high.
- R3: Mode Register Set drives all four command lines low. It puts the burst code on A2..A0, the addressing-mode bit on A3, the CAS latency on A6..A4 and zeros on A11..A7, and pulses mode_ack for one cycle.
- R4: After a Mode Register Set exactly one NOP cycle passes before a pending write's Activate.
- R5: Activate is chip select low, row strobe low, column strobe high, write enable high, with the row on A10..A0 and the bank on A11.
- R6: The write command follows Activate by exactly TRCD cycles. It is encoded as row strobe high, column strobe low, write enable low, with the column on A7..A0, A9..A8 zero, A10 high (auto-precharge) and the bank on A11.
- R7: DQ is driven with the first word in the write cycle and one further host word per cycle. Burst codes 0, 1, 2 and 3 give 1, 2, 4 and 8 words.
- R8: After a write the bus holds NOP for (burst length − 1) + TWR + TRP cycles and wr_ready stays low. A pending request gets its Activate in the very next cycle.
- R9: A mode update requested during a write's lockout waits. Its Mode Register Set appears in the first cycle after the lockout.
- R10: With burst code 7 (full page), the write carries A10 low and 2^COL_W words. A Precharge (row strobe low, column strobe high, write enable low, A10 low, bank on A11) follows TWR cycles after the last word, and the next command comes TRP cycles after the Precharge.
- R11: Reserved burst codes 4, 5 and 6 behave as a burst of one word with auto-precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 1 | Request to program the mode register |
| mode_cas | input | 3 | CAS latency field |
| mode_ilv | input | 1 | Addressing mode bit (0 sequential, 1 interleaved) |
| mode_bl | input | 3 | Burst length code |
| mode_ack | output | 1 | One-cycle pulse when Mode Register Set is issued |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Request accepted at the clock edge when high with wr_valid |
| wr_bank | input | 1 | Target bank |
| wr_row | input | ROW_W (11) | Target row |
| wr_col | input | COL_W (8) | Start column |
| wr_data | input | DQ_W (16) | Write data word offered by the host |
| wd_next | output | 1 | wr_data is taken at this clock edge; host advances |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W+1 (12) | Address bus; top bit selects the bank |
| sd_dq | output | DQ_W (16) | Write data |
| sd_dq_oe | output | 1 | Output enable for sd_dq |

## Verification
The bench holds requests and mode updates pending while the sequencer is busy, so every gap between commands is measured exactly. A lockout counted one cycle short would place the next Activate or Mode Register Set too early, and one counted long would place it late; both show up as a wrong gap. Switching to full-page mode checks that A10 drops and that the explicit Precharge lands TWR cycles after word 256. A design that kept auto-precharge there, or mis-sized the page, would show a wrong address bit or a wrong word count. Reserved burst codes, writes held high before the first programming step, and a Mode Register Set followed too soon by a command are also covered.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  // command lines packed as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_MRS_GAP,
    ST_ACT_WAIT,
    ST_BURST,
    ST_RECOV
  } seq_st_e;
endpackage

// File: rtl/sdw_burst_decode.sv
module sdw_burst_decode #(
  parameter int COL_W = 8,
  parameter int LEN_W = COL_W + 1
) (
  input  logic [2:0]       code,
  output logic [LEN_W-1:0] len,
  output logic             full
);
  always_comb begin
    full = 1'b0;
    unique case (code)
      3'd0:    len = LEN_W'(1);
      3'd1:    len = LEN_W'(2);
      3'd2:    len = LEN_W'(4);
      3'd3:    len = LEN_W'(8);
      3'd7: begin
        len  = LEN_W'(1 << COL_W);
        full = 1'b1;
      end
      default: len = LEN_W'(1);
    endcase
  end
endmodule

// File: rtl/sdw_bus_reg.sv
module sdw_bus_reg
  import sdw_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  sd_cmd_e         cmd_d,
  input  logic [AW-1:0]   addr_d,
  input  logic [DQ_W-1:0] dq_d,
  input  logic            oe_d,
  output logic            cs_n,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic [AW-1:0]   addr,
  output logic [DQ_W-1:0] dq,
  output logic            dq_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
      addr  <= '0;
      dq    <= '0;
      dq_oe <= 1'b0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= cmd_d;
      addr  <= addr_d;
      dq    <= dq_d;
      dq_oe <= oe_d;
    end
  end
endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
  import sdw_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 8,
  parameter int DQ_W  = 16,
  parameter int TRCD  = 2,
  parameter int TWR   = 2,
  parameter int TRP   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_req,
  input  logic [2:0]         mode_cas,
  input  logic               mode_ilv,
  input  logic [2:0]         mode_bl,
  output logic               mode_ack,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic               wr_bank,
  input  logic [ROW_W-1:0]   wr_row,
  input  logic [COL_W-1:0]   wr_col,
  input  logic [DQ_W-1:0]    wr_data,
  output logic               wd_next,
  output logic               sd_cs_n,
  output logic               sd_ras_n,
  output logic               sd_cas_n,
  output logic               sd_we_n,
  output logic [ROW_W:0]     sd_addr,
  output logic [DQ_W-1:0]    sd_dq,
  output logic               sd_dq_oe
);
  localparam int AW     = ROW_W + 1;
  localparam int BA_BIT = AW - 1;
  localparam int AP_BIT = AW - 2;
  localparam int LEN_W  = COL_W + 1;
  localparam int REC    = TWR + TRP;
  localparam int CNT_W  = $clog2((1 << COL_W) + REC + TRCD + 1);

  seq_st_e          st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [2:0]       bl_code_q, bl_code_n;
  logic             bank_q, bank_n;
  logic [COL_W-1:0] col_q, col_n;
  logic             ack_n;
  logic [LEN_W-1:0] len;
  logic             full;

  sd_cmd_e          cmd_d;
  logic [AW-1:0]    addr_d;
  logic             oe_d;

  sdw_burst_decode #(.COL_W(COL_W), .LEN_W(LEN_W)) u_dec (
    .code(bl_code_q), .len(len), .full(full)
  );

  sdw_bus_reg #(.AW(AW), .DQ_W(DQ_W)) u_bus (
    .clk(clk), .rst(rst), .cmd_d(cmd_d), .addr_d(addr_d), .dq_d(wr_data),
    .oe_d(oe_d), .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n),
    .we_n(sd_we_n), .addr(sd_addr), .dq(sd_dq), .dq_oe(sd_dq_oe)
  );

  assign wr_ready = (st == ST_IDLE) && !mode_req;

  always_comb begin
    st_n      = st;
    cnt_n     = cnt;
    bl_code_n = bl_code_q;
    bank_n    = bank_q;
    col_n     = col_q;
    ack_n     = 1'b0;
    cmd_d     = CMD_NOP;
    addr_d    = '0;
    oe_d      = 1'b0;
    wd_next   = 1'b0;
    unique case (st)
      ST_INIT, ST_IDLE: begin
        if (mode_req) begin
          cmd_d       = CMD_MRS;
          addr_d[2:0] = mode_bl;
          addr_d[3]   = mode_ilv;
          addr_d[6:4] = mode_cas;
          bl_code_n   = mode_bl;
          ack_n       = 1'b1;
          st_n        = ST_MRS_GAP;
        end else if (st == ST_IDLE && wr_valid) begin
          cmd_d  = CMD_ACT;
          addr_d = {wr_bank, wr_row};
          bank_n = wr_bank;
          col_n  = wr_col;
          cnt_n  = CNT_W'(TRCD - 1);
          st_n   = ST_ACT_WAIT;
        end
      end
      ST_MRS_GAP: st_n = ST_IDLE;
      ST_ACT_WAIT: begin
        if (cnt == '0) begin
          cmd_d                = CMD_WR;
          addr_d[BA_BIT]       = bank_q;
          addr_d[AP_BIT]       = !full;
          addr_d[COL_W-1:0]    = col_q;
          oe_d                 = 1'b1;
          wd_next              = 1'b1;
          cnt_n                = CNT_W'(len - LEN_W'(1));
          st_n                 = ST_BURST;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_BURST: begin
        if (cnt == '0) begin
          cnt_n = CNT_W'(REC - 2);
          st_n  = ST_RECOV;
        end else begin
          oe_d    = 1'b1;
          wd_next = 1'b1;
          cnt_n   = cnt - 1'b1;
        end
      end
      ST_RECOV: begin
        // explicit row close in full-page mode, TWR cycles after the last word
        if (full && cnt == CNT_W'(TRP - 1)) begin
          cmd_d          = CMD_PRE;
          addr_d[BA_BIT] = bank_q;
        end
        if (cnt == '0) st_n = ST_IDLE;
        else           cnt_n = cnt - 1'b1;
      end
      default: st_n = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_INIT;
      cnt       <= '0;
      bl_code_q <= 3'd0;
      bank_q    <= 1'b0;
      col_q     <= '0;
      mode_ack  <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      bl_code_q <= bl_code_n;
      bank_q    <= bank_n;
      col_q     <= col_n;
      mode_ack  <= ack_n;
    end
  end

  // ---------------- checks on the pin side ----------------
  logic [3:0]     bus_cmd;
  logic [CNT_W:0] since_wr;
  logic [LEN_W-1:0] last_len;
  logic           wrote, mrs_seen;

  assign bus_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      since_wr <= '0;
      last_len <= '0;
      wrote    <= 1'b0;
      mrs_seen <= 1'b0;
    end else begin
      if (bus_cmd == CMD_MRS) mrs_seen <= 1'b1;
      if (bus_cmd == CMD_WR) begin
        since_wr <= (CNT_W+1)'(1);
        last_len <= len;
        wrote    <= 1'b1;
      end else if (since_wr != '1) begin
        since_wr <= since_wr + 1'b1;
      end
    end
  end

  a_r2_mode_before_access: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == CMD_ACT) |-> mrs_seen);
  a_r4_gap_after_mrs: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == CMD_MRS) |=> (bus_cmd == CMD_NOP));
  a_r7_data_with_write: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == CMD_WR) |-> sd_dq_oe);
  a_r8_lockout_held: assert property (@(posedge clk) disable iff (rst)
    ((bus_cmd == CMD_ACT || bus_cmd == CMD_MRS) && wrote) |->
      (int'(since_wr) >= int'(last_len) + REC));
  a_r10_pre_only_full_page: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == CMD_PRE) |-> (full && !sd_addr[AP_BIT]));
endmodule

// File: tb/sdram_wr_seq_bench.sv
`timescale 1ns/1ps
module sdram_wr_seq_bench;
  localparam int ROW_W = 11;
  localparam int COL_W = 8;
  localparam int DQ_W  = 16;
  localparam int TRCD  = 3;
  localparam int TWR   = 2;
  localparam int TRP   = 3;
  localparam int AW    = ROW_W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_req = 1'b0;
  logic [2:0] mode_cas = 3'd0;
  logic mode_ilv = 1'b0;
  logic [2:0] mode_bl = 3'd0;
  logic mode_ack;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic wr_bank = 1'b0;
  logic [ROW_W-1:0] wr_row = '0;
  logic [COL_W-1:0] wr_col = '0;
  logic [DQ_W-1:0] wr_data;
  logic wd_next;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [AW-1:0] sd_addr;
  logic [DQ_W-1:0] sd_dq;
  logic sd_dq_oe;

  always #2.5 clk = ~clk;

  sdram_wr_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
                 .TRCD(TRCD), .TWR(TWR), .TRP(TRP)) u_sdram_wr_seq (
    .clk(clk), .rst(rst), .mode_req(mode_req), .mode_cas(mode_cas),
    .mode_ilv(mode_ilv), .mode_bl(mode_bl), .mode_ack(mode_ack),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_bank(wr_bank),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data), .wd_next(wd_next),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_dq(sd_dq), .sd_dq_oe(sd_dq_oe)
  );

  function automatic logic [DQ_W-1:0] word_of(int n);
    return DQ_W'(16'h1234 + n * 16'h0107);
  endfunction

  // host data source: advances on every take strobe
  int dctr;
  assign wr_data = word_of(dctr);
  always @(posedge clk) begin
    if (rst) dctr <= 0;
    else if (wd_next) dctr <= dctr + 1;
  end

  typedef struct {
    logic [3:0]      cmd;
    logic [AW-1:0]   addr;
    logic            oe;
    logic [DQ_W-1:0] dq;
    int              delta;
    string           tag;
  } ev_t;

  ev_t expq[$];
  int n_chk = 0, n_err = 0, n_ev = 0;
  int gap = 100000;
  int wexp = 0;
  int follow = -1;
  string ftag = "R3";
  int cur_len = 1;
  bit cur_full = 1'b0;
  bit cur_rsv = 1'b0;

  task automatic check(string tag, bit ok, string what);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  function automatic void push(logic [3:0] c, logic [AW-1:0] a, logic oe,
                               logic [DQ_W-1:0] d, int dl, string tg);
    ev_t e;
    e.cmd = c; e.addr = a; e.oe = oe; e.dq = d; e.delta = dl; e.tag = tg;
    expq.push_back(e);
  endfunction

  // monitor: compares every non-idle bus cycle against the scoreboard
  always @(negedge clk) begin
    logic [3:0] bc;
    bit ok;
    ev_t e;
    if (rst) begin
      gap = 100000;
    end else begin
      bc = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (bc != 4'b0111 || sd_dq_oe) begin
        n_ev++;
        if (expq.size() == 0) begin
          check("R8", 1'b0, $sformatf("unexpected event actual cmd=%b addr=%h oe=%b expected none",
                bc, sd_addr, sd_dq_oe));
        end else begin
          e = expq.pop_front();
          ok = (bc == e.cmd) && (sd_addr == e.addr) && (sd_dq_oe == e.oe);
          if (e.oe) ok = ok && (sd_dq == e.dq);
          if (e.delta >= 0) ok = ok && (gap == e.delta);
          check(e.tag, ok, $sformatf(
            "actual cmd=%b addr=%h oe=%b dq=%h gap=%0d expected cmd=%b addr=%h oe=%b dq=%h gap=%0d",
            bc, sd_addr, sd_dq_oe, sd_dq, gap, e.cmd, e.addr, e.oe, e.dq, e.delta));
        end
        gap = 1;
      end else if (gap < 100000) begin
        gap = gap + 1;
      end
    end
  end

  function automatic int len_of(logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 1 << COL_W;
      default: return 1;
    endcase
  endfunction

  task automatic do_mode(logic [2:0] cas, logic ilv, logic [2:0] code, string tg);
    logic [AW-1:0] a;
    a = '0; a[2:0] = code; a[3] = ilv; a[6:4] = cas;
    push(4'b0000, a, 1'b0, '0, follow, tg);
    cur_len  = len_of(code);
    cur_full = (code == 3'd7);
    cur_rsv  = (code >= 3'd4 && code <= 3'd6);
    mode_cas = cas; mode_ilv = ilv; mode_bl = code;
    mode_req = 1'b1;
    forever begin
      @(negedge clk);
      if (mode_ack) break;
    end
    mode_req = 1'b0;
    follow = 2;
    ftag   = "R4";
  endtask

  task automatic do_write(logic bank, logic [ROW_W-1:0] row, logic [COL_W-1:0] col);
    logic [AW-1:0] a;
    string bt;
    push(4'b0011, {bank, row}, 1'b0, '0, follow, ftag == "R3" ? "R5" : ftag);
    a = '0; a[AW-1] = bank; a[AW-2] = !cur_full; a[COL_W-1:0] = col;
    bt = cur_full ? "R10" : (cur_rsv ? "R11" : "R7");
    push(4'b0100, a, 1'b1, word_of(wexp), TRCD, "R6");
    wexp++;
    for (int i = 1; i < cur_len; i++) begin
      push(4'b0111, '0, 1'b1, word_of(wexp), 1, bt);
      wexp++;
    end
    if (cur_full) begin
      a = '0; a[AW-1] = bank;
      push(4'b0010, a, 1'b0, '0, TWR + 1, "R10");
      follow = TRP;
      ftag   = "R10";
    end else begin
      follow = TWR + TRP + 1;
      ftag   = "R8";
    end
    wr_bank = bank; wr_row = row; wr_col = col;
    wr_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (wr_ready) begin
        @(negedge clk);
        break;
      end
    end
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("R8", 1'b0, "watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1", sd_cs_n == 1'b0 && sd_ras_n && sd_cas_n && sd_we_n && !sd_dq_oe && !wr_ready && !mode_ack,
          $sformatf("reset actual cmd=%b%b%b%b oe=%b rdy=%b ack=%b expected 0111 0 0 0",
                    sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe, wr_ready, mode_ack));
    rst = 1'b0;
    @(negedge clk);
    check("R1", sd_cs_n == 1'b0 && sd_ras_n && sd_cas_n && sd_we_n && !sd_dq_oe && !wr_ready,
          $sformatf("after reset actual cmd=%b%b%b%b oe=%b rdy=%b expected 0111 0 0",
                    sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe, wr_ready));
    // R2: requests before the first mode programming are held off
    wr_valid = 1'b1; wr_bank = 1'b1; wr_row = 11'h3FF;
    repeat (12) begin
      @(negedge clk);
      if (wr_ready) check("R2", 1'b0, "ready high before mode set actual=1 expected=0");
    end
    check("R2", n_ev == 0 && !wr_ready,
          $sformatf("before mode set actual events=%0d rdy=%b expected 0 0", n_ev, wr_ready));
    wr_valid = 1'b0;

    do_mode(3'd2, 1'b0, 3'd1, "R3");
    do_write(1'b0, 11'h155, 8'h10);
    do_write(1'b1, 11'h2AA, 8'hF0);
    do_mode(3'd3, 1'b1, 3'd0, "R9");
    do_write(1'b1, 11'h001, 8'h00);
    do_write(1'b0, 11'h7FF, 8'hFF);
    do_mode(3'd2, 1'b0, 3'd3, "R9");
    do_write(1'b0, 11'h0F0, 8'h08);
    do_write(1'b1, 11'h50A, 8'h80);
    do_mode(3'd2, 1'b0, 3'd5, "R9");
    do_write(1'b1, 11'h123, 8'h33);
    do_write(1'b0, 11'h456, 8'h44);
    do_mode(3'd1, 1'b1, 3'd7, "R9");
    do_write(1'b1, 11'h00F, 8'h00);
    do_write(1'b0, 11'h0F0, 8'h00);
    do_mode(3'd2, 1'b0, 3'd2, "R10");
    do_write(1'b0, 11'h3C3, 8'h3C);

    for (int t = 0; t < 2000 && expq.size() != 0; t++) @(negedge clk);
    repeat (20) @(negedge clk);
    check("R8", expq.size() == 0,
          $sformatf("scoreboard drain actual left=%0d expected 0", expq.size()));
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule